// File: doc/BRIEF.md
# Three-Plane Framebuffer Raster Scanout

This block reads a colour framebuffer stored as three separate bit-planes, one each for red, green and blue. It turns the bytes it fetches into a stream of RGB pixels for a raster display. A word counter and a line counter step through the memory. At each read address every plane returns one 8-bit word, so a single fetch yields 24 bits. The three words are then cut into equal slices that leave the block one per clock.

A two-bit depth mode sets how many bits make up one channel of a pixel. It can be 8, 4, 2 or 1 bits, which gives 1, 2, 4 or 8 pixels per fetched word. Fetch timing is the same in every mode. A line is always 53 words, so the visible width is 53, 106, 212 or 424 pixels, over 256 lines.

The horizontal counter ends a line on an equality match with 53. The line-done strobe follows one clock after that match. The memory is external and has a plain synchronous read port with one cycle of latency.

Top module: `fb_scanout`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `rd_en`, `line_done`, `frame_start`, `pix_valid` and all pixel outputs are 0.
- R2: Every read has `rd_addr` = line × 53 + word. Word runs 0..52 and line runs 0..255. There is exactly one read per word, issued in the cycle the word's first slice starts.
- R3: The word counter reaches 53 and stays there for one cycle with no read. `line_done` is a one-cycle pulse on the next clock, in the first cycle of the following line. The distance between consecutive line-start markers (`line_done` or `frame_start`) is 53 × S + 1 cycles, where S is the number of pixels per word.
- R4: The line counter wraps from 255 to 0. `frame_start` pulses in the first cycle of line 0, which is the cycle that fetches address 0. This happens together with every 256th `line_done`, and also two cycles after reset falls.
- R5: Depth mode encoding: 0 gives 8-bit channels (1 pixel/word, 53 per line). 1 gives 4-bit channels (2 pixels, 106). 2 gives 2-bit channels (4 pixels, 212). 3 gives 1-bit channels (8 pixels, 424).
- R6: Slices leave each word most-significant first. A slice is placed in the low bits of its 8-bit pixel output, and the bits above it are zero. Red comes from `rd_red`, green from `rd_green` and blue from `rd_blue`.
- R7: The first pixel of a word is valid two cycles after the read of that word. `pix_valid` stays high for all 53 × S pixels of a line without a gap.
- R8: `depth_mode` is sampled only when a frame starts. A change during a frame has no effect on that frame's pixels or line period.
- R9: While `pix_valid` is low, all three pixel outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| depth_mode | input | 2 | Bits-per-channel select, sampled at frame start |
| rd_en | output | 1 | Read strobe to the plane memory |
| rd_addr | output | 14 | Read address, shared by all three planes |
| rd_red | input | 8 | Red plane word, valid one cycle after `rd_en` |
| rd_green | input | 8 | Green plane word |
| rd_blue | input | 8 | Blue plane word |
| pix_red | output | 8 | Red channel of the current pixel, right-aligned |
| pix_green | output | 8 | Green channel of the current pixel |
| pix_blue | output | 8 | Blue channel of the current pixel |
| pix_valid | output | 1 | Pixel outputs hold a pixel |
| line_done | output | 1 | One-cycle pulse one clock after the word counter matches 53 |
| frame_start | output | 1 | One-cycle pulse at the first cycle of line 0 |

## Verification
The bench runs whole frames in every depth mode and compares each pixel with a reference slice of a computed memory image.

- **Comparator timing.** An off-by-one comparator would produce 52 or 54 words per line. That shows up as a wrong line period and as a misplaced `line_done` or `frame_start` pulse.
- **Frame-boundary hand-off.** Here the last pixel of line 255 coincides with the frame-start pulse. A serializer that picked up the new depth mode too early would corrupt that final pixel.
- **Mode changes during a frame.** These are driven on purpose. A design that sampled the mode at the wrong time would change the line period mid-frame.
- **Reset in the middle of a line.** This checks that pixels in flight are dropped and that the scan restarts at address 0.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

    localparam int PLANE_W     = 8;
    localparam int SLICE_IDX_W = $clog2(PLANE_W);

    // bits per channel: 8 >> mode, pixels per word: 1 << mode
    typedef enum logic [1:0] {
        DEPTH_8 = 2'd0,
        DEPTH_4 = 2'd1,
        DEPTH_2 = 2'd2,
        DEPTH_1 = 2'd3
    } depth_e;

    typedef logic [SLICE_IDX_W-1:0] slice_t;

    function automatic slice_t last_slice(depth_e m);
        return slice_t'((1 << m) - 1);
    endfunction

    function automatic logic [SLICE_IDX_W:0] slice_bits(depth_e m);
        return (SLICE_IDX_W+1)'(PLANE_W >> m);
    endfunction

endpackage

// File: rtl/fbs_scan_ctrl.sv
module fbs_scan_ctrl
    import fbs_pkg::*;
#(
    parameter int WORDS  = 53,
    parameter int LINES  = 256,
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  depth_e            depth_mode,
    output logic              fetch,
    output logic [ADDR_W-1:0] fetch_addr,
    output depth_e            fetch_mode,
    output logic              line_done,
    output logic              frame_start
);

    localparam int WC_W = $clog2(WORDS + 1);
    localparam int LN_W = $clog2(LINES);

    typedef struct packed {
        logic            running;
        logic [WC_W-1:0] wc;
        slice_t          sl;
        logic [LN_W-1:0] line;
        depth_e          mode;
        logic            done;
        logic            fstart;
    } scan_t;

    scan_t scan_q, scan_d;
    logic  match;

    always_comb begin
        match         = (scan_q.wc == WC_W'(WORDS));
        scan_d        = scan_q;
        scan_d.done   = 1'b0;
        scan_d.fstart = 1'b0;
        if (!scan_q.running) begin
            scan_d.running = 1'b1;
            scan_d.mode    = depth_mode;
            scan_d.fstart  = 1'b1;
        end else if (match) begin
            scan_d.wc   = '0;
            scan_d.sl   = '0;
            scan_d.done = 1'b1;
            if (scan_q.line == LN_W'(LINES - 1)) begin
                scan_d.line   = '0;
                scan_d.mode   = depth_mode;
                scan_d.fstart = 1'b1;
            end else begin
                scan_d.line = scan_q.line + 1'b1;
            end
        end else if (scan_q.sl == last_slice(scan_q.mode)) begin
            scan_d.sl = '0;
            scan_d.wc = scan_q.wc + 1'b1;
        end else begin
            scan_d.sl = scan_q.sl + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) scan_q <= '0;
        else     scan_q <= scan_d;
    end

    assign fetch       = scan_q.running & ~match & (scan_q.sl == '0);
    assign fetch_addr  = ADDR_W'(scan_q.line) * ADDR_W'(WORDS) + ADDR_W'(scan_q.wc);
    assign fetch_mode  = scan_q.mode;
    assign line_done   = scan_q.done;
    assign frame_start = scan_q.fstart;

    // depth mode may only move at a frame boundary
    assert_mode_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (scan_q.running && !scan_d.fstart) |=> $stable(scan_q.mode));

    // the match cycle is followed by a cleared counter and the done strobe
    assert_match_then_done_R3: assert property (@(posedge clk) disable iff (rst)
        match |=> (scan_q.wc == '0 && line_done));

endmodule

// File: rtl/fbs_plane_shift.sv
module fbs_plane_shift
    import fbs_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               shift,
    input  depth_e             mode,
    input  logic [PLANE_W-1:0] din,
    output logic [PLANE_W-1:0] pix
);

    typedef struct packed {
        logic [PLANE_W-1:0] sh;
        logic [PLANE_W-1:0] px;
    } plane_t;

    plane_t                pl_q, pl_d;
    logic [PLANE_W-1:0]    src;
    logic [SLICE_IDX_W:0]  width;

    always_comb begin
        src   = load ? din : pl_q.sh;
        width = slice_bits(mode);
        pl_d  = pl_q;
        pl_d.px = '0;
        if (load || shift) begin
            pl_d.px = src >> (PLANE_W - int'(width));
            pl_d.sh = src << width;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pl_q <= '0;
        else     pl_q <= pl_d;
    end

    assign pix = pl_q.px;

    // a slice never spills above its width
    assert_upper_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (load || shift) |=> ((pl_q.px >> $past(width)) == '0));

endmodule

// File: rtl/fbs_serializer.sv
module fbs_serializer
    import fbs_pkg::*;
#(
    parameter int CHANNELS = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        fetch,
    input  depth_e                      fetch_mode,
    input  logic [CHANNELS*PLANE_W-1:0] rd_data,
    output logic [CHANNELS*PLANE_W-1:0] pix,
    output logic                        pix_valid
);

    typedef struct packed {
        logic   ld;
        depth_e ld_mode;
        slice_t rem;
        depth_e mode;
        logic   valid;
    } ser_t;

    ser_t   ser_q, ser_d;
    logic   load, shift;
    depth_e op_mode;

    always_comb begin
        load    = ser_q.ld;
        shift   = ~ser_q.ld & (ser_q.rem != '0);
        op_mode = ser_q.ld ? ser_q.ld_mode : ser_q.mode;
        ser_d         = ser_q;
        ser_d.ld      = fetch;
        ser_d.ld_mode = fetch_mode;
        ser_d.valid   = load | shift;
        if (load) begin
            ser_d.rem  = last_slice(ser_q.ld_mode);
            ser_d.mode = ser_q.ld_mode;
        end else if (shift) begin
            ser_d.rem = ser_q.rem - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ser_q <= '0;
        else     ser_q <= ser_d;
    end

    for (genvar c = 0; c < CHANNELS; c++) begin : g_plane
        fbs_plane_shift u_plane (
            .clk   (clk),
            .rst   (rst),
            .load  (load),
            .shift (shift),
            .mode  (op_mode),
            .din   (rd_data[c*PLANE_W +: PLANE_W]),
            .pix   (pix[c*PLANE_W +: PLANE_W])
        );
    end

    assign pix_valid = ser_q.valid;

    // a fresh word only arrives once the previous one has drained
    assert_load_after_drain_R7: assert property (@(posedge clk) disable iff (rst)
        ser_q.ld |-> (ser_q.rem == '0));

endmodule

// File: rtl/fb_scanout.sv
module fb_scanout
    import fbs_pkg::*;
#(
    parameter int WORDS  = 53,
    parameter int LINES  = 256,
    parameter int ADDR_W = 14
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         depth_mode,
    output logic               rd_en,
    output logic [ADDR_W-1:0]  rd_addr,
    input  logic [PLANE_W-1:0] rd_red,
    input  logic [PLANE_W-1:0] rd_green,
    input  logic [PLANE_W-1:0] rd_blue,
    output logic [PLANE_W-1:0] pix_red,
    output logic [PLANE_W-1:0] pix_green,
    output logic [PLANE_W-1:0] pix_blue,
    output logic               pix_valid,
    output logic               line_done,
    output logic               frame_start
);

    localparam int CHANNELS = 3;

    depth_e                      fetch_mode;
    logic [CHANNELS*PLANE_W-1:0] rd_word;
    logic [CHANNELS*PLANE_W-1:0] pix_word;

    assign rd_word = {rd_red, rd_green, rd_blue};

    fbs_scan_ctrl #(
        .WORDS  (WORDS),
        .LINES  (LINES),
        .ADDR_W (ADDR_W)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .depth_mode  (depth_e'(depth_mode)),
        .fetch       (rd_en),
        .fetch_addr  (rd_addr),
        .fetch_mode  (fetch_mode),
        .line_done   (line_done),
        .frame_start (frame_start)
    );

    fbs_serializer #(
        .CHANNELS (CHANNELS)
    ) u_ser (
        .clk        (clk),
        .rst        (rst),
        .fetch      (rd_en),
        .fetch_mode (fetch_mode),
        .rd_data    (rd_word),
        .pix        (pix_word),
        .pix_valid  (pix_valid)
    );

    assign {pix_red, pix_green, pix_blue} = pix_word;

    assert_addr_range_R2: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (int'(rd_addr) < WORDS * LINES));

    assert_done_after_gap_R3: assert property (@(posedge clk) disable iff (rst)
        line_done |-> (!$past(rd_en) && $past(!line_done)));

    assert_frame_at_zero_R4: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> (rd_en && rd_addr == '0));

    assert_quiet_pixels_R9: assert property (@(posedge clk) disable iff (rst)
        !pix_valid |-> (pix_red == '0 && pix_green == '0 && pix_blue == '0));

endmodule

// File: tb/fb_scanout_test.sv
module fb_scanout_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  depth_mode = 2'd1;
    logic        rd_en;
    logic [13:0] rd_addr;
    logic [7:0]  rd_red = '0, rd_green = '0, rd_blue = '0;
    logic [7:0]  pix_red, pix_green, pix_blue;
    logic        pix_valid, line_done, frame_start;

    always #5 clk = ~clk;

    fb_scanout uut (
        .clk(clk), .rst(rst), .depth_mode(depth_mode),
        .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_red(rd_red), .rd_green(rd_green), .rd_blue(rd_blue),
        .pix_red(pix_red), .pix_green(pix_green), .pix_blue(pix_blue),
        .pix_valid(pix_valid), .line_done(line_done), .frame_start(frame_start)
    );

    int unsigned key;
    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    function automatic logic [23:0] mem_word(int a);
        logic [7:0] r, g, b;
        r = 8'((a * 29 + int'(key)) ^ (a >> 7));
        g = 8'((a * 113 + int'(key >> 8)) ^ (a >> 3));
        b = 8'(a * 61 + 17 + int'(key >> 16));
        return {r, g, b};
    endfunction

    function automatic int exp_slice(int d, int m, int k);
        int w = 8 >> m;
        return (d >> (8 - w * (k + 1))) & ((1 << w) - 1);
    endfunction

    // synchronous read port, one cycle latency
    always @(posedge clk) begin
        if (rd_en) {rd_red, rd_green, rd_blue} <= mem_word(int'(rd_addr));
    end

    task automatic chk(bit ok, string req, int act, int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    // bench tracking state
    int fl, fw, pl, pw, ps;
    int px_mode, pend_mode, line_mode;
    int cnt, done_in_frame, frames_seen = 0, post_rst, rst_cycles = 0;
    bit have_mark, first_fs;
    bit fh1_en, fh2_en;
    int fh1_addr, fh2_addr;

    always @(negedge clk) begin
        if (rst) begin
            fl = 0; fw = 0; pl = 0; pw = 0; ps = 0;
            cnt = 0; done_in_frame = 0; post_rst = 0;
            have_mark = 0; first_fs = 1;
            fh1_en = 0; fh2_en = 0; fh1_addr = 0; fh2_addr = 0;
            if (rst_cycles > 0)
                chk(!rd_en && !line_done && !frame_start && !pix_valid &&
                    pix_red == 0 && pix_green == 0 && pix_blue == 0,
                    "R1 outputs in reset", {rd_en, line_done, frame_start, pix_valid}, 0);
            rst_cycles++;
        end else begin
            rst_cycles = 0;
            post_rst++;
            if (post_rst == 1)
                chk(!rd_en && !frame_start && !pix_valid && !line_done,
                    "R1 idle after reset", {rd_en, frame_start, pix_valid, line_done}, 0);
            if (post_rst == 2)
                chk(frame_start == 1'b1, "R4 first frame start", frame_start, 1);

            // line period and frame cadence
            cnt++;
            if (line_done) begin
                chk(have_mark && cnt == 53 * (1 << line_mode) + 1,
                    "R3,R8 line period", cnt, 53 * (1 << line_mode) + 1);
                done_in_frame++;
                chk(frame_start == (done_in_frame == 256), "R4 frame cadence",
                    frame_start, int'(done_in_frame == 256));
                if (done_in_frame == 256) done_in_frame = 0;
            end
            if (line_done || frame_start) begin
                cnt = 0;
                have_mark = 1;
            end
            if (frame_start) begin
                frames_seen++;
                chk(fl == 0 && fw == 0, "R4 frame start at address 0", fl * 53 + fw, 0);
                pend_mode = int'(depth_mode);
                line_mode = int'(depth_mode);
                if (first_fs) begin
                    px_mode = int'(depth_mode);
                    first_fs = 0;
                end
            end

            // read addresses
            if (rd_en) begin
                chk(int'(rd_addr) == fl * 53 + fw, "R2 read address", int'(rd_addr), fl * 53 + fw);
                fw++;
                if (fw == 53) begin
                    fw = 0;
                    fl = (fl + 1) % 256;
                end
            end

            // pixel stream
            if (pix_valid) begin
                logic [23:0] d;
                int er, eg, eb;
                if (ps == 0)
                    chk(fh2_en && fh2_addr == pl * 53 + pw, "R7 two-cycle latency",
                        fh2_addr, pl * 53 + pw);
                d  = mem_word(pl * 53 + pw);
                er = exp_slice(int'(d[23:16]), px_mode, ps);
                eg = exp_slice(int'(d[15:8]),  px_mode, ps);
                eb = exp_slice(int'(d[7:0]),   px_mode, ps);
                chk(int'(pix_red) == er && int'(pix_green) == eg && int'(pix_blue) == eb,
                    "R5 R6 pixel value",
                    int'({pix_red, pix_green, pix_blue}), (er << 16) | (eg << 8) | eb);
                ps++;
                if (ps == (1 << px_mode)) begin
                    ps = 0;
                    pw++;
                    if (pw == 53) begin
                        pw = 0;
                        pl++;
                        if (pl == 256) begin
                            pl = 0;
                            px_mode = pend_mode;
                        end
                    end
                end
            end else begin
                chk(pix_red == 0 && pix_green == 0 && pix_blue == 0, "R9 quiet outputs",
                    int'({pix_red, pix_green, pix_blue}), 0);
                chk(ps == 0 && pw == 0, "R7 no gap inside a line", pw * 8 + ps, 0);
            end

            fh2_en = fh1_en;
            fh2_addr = fh1_addr;
            fh1_en = rd_en;
            fh1_addr = int'(rd_addr);
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        key = $urandom(32'd4711);
        key = $urandom;
        rst = 1'b1;
        depth_mode = 2'd1;
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // frame 1 at 4-bit depth, with mid-frame mode changes that must be ignored (R8)
        wait (frames_seen == 1);
        repeat (50 * 107) @(negedge clk);
        depth_mode = 2'($urandom_range(2, 3));
        repeat (100 * 107) @(negedge clk);
        depth_mode = 2'd0;

        // frame 2 at 8-bit depth (R5)
        wait (frames_seen == 2);
        repeat (100 * 54) @(negedge clk);
        depth_mode = 2'd2;

        // frame 3 at 2-bit depth
        wait (frames_seen == 3);
        repeat (60 * 213) @(negedge clk);
        depth_mode = 2'd3;

        // frame 4 at 1-bit depth, then a reset in the middle of a line (R1)
        wait (frames_seen == 4);
        repeat (20 * 425 + 37) @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (3 * 425 + 10) @(negedge clk);
        report();
    end

endmodule